// File: doc/BRIEF.md
# Debug Session Handshake Controller

This block sits on the scan-clock side of a processor debug port. It tracks one debug session. While the port is enabled, an active-low external event input can ask the core to stop. The block turns that event into a held entry request toward the core. When the core reports that it has reached debug state, the block returns an acknowledge pulse of fixed length. That pulse can drive the enable of an open-drain pull-down on a shared board-level event line.

An active-low session flag tells other on-chip units that a debug session is open. Those units may change their behaviour while the flag is low. The flag drops the first time the core enters debug state. It stays low while the core steps in and out of debug state one instruction at a time. It rises again only when the debug port issues a release command.

The block also decodes the command-register update that carries go and exit with no register selected. It reports that update as a one-cycle strobe so that other modules can leave debug mode in step with the core. Separately, a status input that says the core clock is running is brought into the scan-clock domain. It is shown as a status bit while the instruction register is being shifted.

Top module: `dbg_session_ctrl`

## Requirements
- R1: While reset is asserted, the outputs are held as follows: entry_req 0, ack_en 0, session_n 1, go_exit_stb 0, clk_run_sync 0. Internal release from reset happens on the second rising tck edge after rst_n goes high.
- R2: On a tck edge where port_en is 1, evt_req_n is 0, core_in_dbg is 0 and no acknowledge is active, entry_req becomes 1. When port_en is 0, evt_req_n has no effect. Once set, entry_req holds until R3 clears it.
- R3: entry_req returns to 0 on the edge where core_in_dbg is first seen high after being low (an entry edge).
- R4: Each entry edge makes ack_en high for exactly 3 consecutive tck cycles, starting with that edge.
- R5: An event request (evt_req_n low) that arrives while ack_en is high is ignored. entry_req stays 0.
- R6: session_n goes to 0 on the first entry edge. It stays 0 across later exits from debug state and later entries.
- R7: session_n goes to 1 on an edge where upd_dr, cmd_go and cmd_ex are all 1 and cmd_rsel is either 7'h7F (no register) or 7'h10 (core scan chain). If an entry edge falls on the same edge, the entry wins and session_n is 0. With any other cmd_rsel value, or with go or exit low, session_n does not change.
- R8: go_exit_stb is 1 for one cycle, on the edge after upd_dr, cmd_go and cmd_ex are all 1 with cmd_rsel = 7'h7F. This happens whether or not the core is in debug state. The 7'h10 release does not raise the strobe.
- R9: clk_run_sync follows clk_run_async after two tck edges. ir_status equals clk_run_sync while shift_ir is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| port_en | input | 1 | Debug port enabled; gates the event input |
| evt_req_n | input | 1 | Active-low external debug event request |
| core_in_dbg | input | 1 | Core reports that it is in debug state |
| upd_dr | input | 1 | TAP is in Update-DR |
| cmd_go | input | 1 | Go bit of the command being updated |
| cmd_ex | input | 1 | Exit bit of the command being updated |
| cmd_rsel | input | 7 | Register-select field of the command |
| clk_run_async | input | 1 | Core clock running status, asynchronous to tck |
| shift_ir | input | 1 | TAP is in Shift-IR |
| entry_req | output | 1 | Debug entry request toward the core |
| ack_en | output | 1 | Entry acknowledge / open-drain pull-down enable |
| session_n | output | 1 | Active-low debug session flag |
| go_exit_stb | output | 1 | Strobe for a go+exit update with no register selected |
| clk_run_sync | output | 1 | Synchronized core clock running status |
| ir_status | output | 1 | Clock status bit presented during Shift-IR |

## Verification
Every registered result is due one tck edge after the stimulus that causes it:
- entry_req, session_n and go_exit_stb change on that next edge.
- ack_en rises on the entry edge itself and stays high through the two edges that follow.
- clk_run_sync needs two edges.
- ir_status is combinational from shift_ir.

The bench drives all inputs just after a falling edge. It lets exactly the required number of rising edges pass and reads the outputs on the following falling edge. Each table row therefore holds the value expected one edge later, and the directed tests count edges the same way. For reset, the bench allows the two-edge release delay before it applies any stimulus.

// File: rtl/dbg_sess_pkg.sv
package dbg_sess_pkg;
  localparam int RSEL_W = 7;
  localparam logic [RSEL_W-1:0] RSEL_NONE       = 7'h7F;
  localparam logic [RSEL_W-1:0] RSEL_CORE_CHAIN = 7'h10;

  function automatic logic go_exit_cmd(input logic upd, input logic go, input logic ex);
    return upd & go & ex;
  endfunction
endpackage

// File: rtl/dbg_sync_chain.sv
module dbg_sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb stg_d[0] = d;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_comb stg_d[i] = stg_q[i-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dbg_entry_ack.sv
module dbg_entry_ack #(
  parameter int ACK_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic port_en,
  input  logic evt_req_n,
  input  logic core_in_dbg,
  output logic entry_req,
  output logic ack_en,
  output logic entry_rise
);
  localparam int CNT_W = $clog2(ACK_LEN + 1);

  logic             dbg_q;
  logic             req_q, req_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, busy, evt_take;

  // next-state logic
  always_comb begin
    entry_rise = core_in_dbg & ~dbg_q;
    busy       = (cnt_q != '0);
    evt_take   = port_en & ~evt_req_n & ~busy & ~core_in_dbg;

    req_d = req_q;
    if (entry_rise)    req_d = 1'b0;
    else if (evt_take) req_d = 1'b1;

    cnt_en = entry_rise | busy;
    cnt_d  = entry_rise ? CNT_W'(ACK_LEN) : (cnt_q - CNT_W'(1));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q <= 1'b0;
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      dbg_q <= core_in_dbg;
      req_q <= req_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign entry_req = req_q;
  assign ack_en    = busy;
endmodule

// File: rtl/dbg_session_track.sv
module dbg_session_track
  import dbg_sess_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_rise,
  input  logic              upd_dr,
  input  logic              cmd_go,
  input  logic              cmd_ex,
  input  logic [RSEL_W-1:0] cmd_rsel,
  output logic              session_n,
  output logic              go_exit_stb
);
  logic sess_q, sess_d;
  logic stb_q, stb_d;
  logic cmd_hit, release_cmd;

  always_comb begin
    cmd_hit     = go_exit_cmd(upd_dr, cmd_go, cmd_ex);
    release_cmd = cmd_hit & ((cmd_rsel == RSEL_NONE) | (cmd_rsel == RSEL_CORE_CHAIN));
    stb_d       = cmd_hit & (cmd_rsel == RSEL_NONE);

    sess_d = sess_q;
    if (entry_rise)       sess_d = 1'b0;
    else if (release_cmd) sess_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_q <= 1'b1;
      stb_q  <= 1'b0;
    end else begin
      sess_q <= sess_d;
      stb_q  <= stb_d;
    end
  end

  assign session_n   = sess_q;
  assign go_exit_stb = stb_q;
endmodule

// File: rtl/dbg_session_ctrl.sv
module dbg_session_ctrl #(
  parameter int ACK_LEN     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            tck,
  input  logic                            rst_n,
  input  logic                            port_en,
  input  logic                            evt_req_n,
  input  logic                            core_in_dbg,
  input  logic                            upd_dr,
  input  logic                            cmd_go,
  input  logic                            cmd_ex,
  input  logic [dbg_sess_pkg::RSEL_W-1:0] cmd_rsel,
  input  logic                            clk_run_async,
  input  logic                            shift_ir,
  output logic                            entry_req,
  output logic                            ack_en,
  output logic                            session_n,
  output logic                            go_exit_stb,
  output logic                            clk_run_sync,
  output logic                            ir_status
);
  logic rst_q_n;
  logic entry_rise;

  // reset: asserted asynchronously, released on a clock edge
  dbg_sync_chain #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(tck), .rst_n(rst_n), .d(1'b1), .q(rst_q_n)
  );

  dbg_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_clk_sync (
    .clk(tck), .rst_n(rst_q_n), .d(clk_run_async), .q(clk_run_sync)
  );

  dbg_entry_ack #(.ACK_LEN(ACK_LEN)) u_entry (
    .clk(tck), .rst_n(rst_q_n), .port_en(port_en), .evt_req_n(evt_req_n),
    .core_in_dbg(core_in_dbg), .entry_req(entry_req), .ack_en(ack_en),
    .entry_rise(entry_rise)
  );

  dbg_session_track u_sess (
    .clk(tck), .rst_n(rst_q_n), .entry_rise(entry_rise), .upd_dr(upd_dr),
    .cmd_go(cmd_go), .cmd_ex(cmd_ex), .cmd_rsel(cmd_rsel),
    .session_n(session_n), .go_exit_stb(go_exit_stb)
  );

  assign ir_status = shift_ir & clk_run_sync;
endmodule

// File: rtl/dbg_session_chk.sv
module dbg_session_chk
  import dbg_sess_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              port_en,
  input logic              evt_req_n,
  input logic              core_in_dbg,
  input logic              upd_dr,
  input logic              cmd_go,
  input logic              cmd_ex,
  input logic [RSEL_W-1:0] cmd_rsel,
  input logic              clk_run_async,
  input logic              shift_ir,
  input logic              entry_req,
  input logic              ack_en,
  input logic              session_n,
  input logic              go_exit_stb,
  input logic              clk_run_sync,
  input logic              ir_status
);
  p_req_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry_req && (!port_en || evt_req_n)) |=> !entry_req);

  p_req_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_in_dbg) |=> !entry_req);

  p_ack_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_in_dbg) |=> ack_en);

  p_req_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !entry_req) |=> !entry_req);

  p_sess_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_in_dbg) |=> !session_n);

  p_sess_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(session_n) |-> $past(upd_dr && cmd_go && cmd_ex &&
      (cmd_rsel == RSEL_NONE || cmd_rsel == RSEL_CORE_CHAIN)));

  p_stb_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_dr && cmd_go && cmd_ex && cmd_rsel == RSEL_NONE) |=> go_exit_stb);

  p_stb_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_exit_stb |-> $past(upd_dr && cmd_go && cmd_ex && cmd_rsel == RSEL_NONE));

  p_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_run_sync |-> $past(clk_run_async, 2));

  p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ir_status |-> (shift_ir && clk_run_sync));
endmodule

bind dbg_session_ctrl dbg_session_chk u_chk (
  .clk(tck), .rst_n(rst_q_n), .port_en(port_en), .evt_req_n(evt_req_n),
  .core_in_dbg(core_in_dbg), .upd_dr(upd_dr), .cmd_go(cmd_go), .cmd_ex(cmd_ex),
  .cmd_rsel(cmd_rsel), .clk_run_async(clk_run_async), .shift_ir(shift_ir),
  .entry_req(entry_req), .ack_en(ack_en), .session_n(session_n),
  .go_exit_stb(go_exit_stb), .clk_run_sync(clk_run_sync), .ir_status(ir_status)
);

// File: tb/tb_dbg_session_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_session_ctrl;
  logic       tck = 1'b0;
  logic       rst_n, port_en, evt_req_n, core_in_dbg, upd_dr, cmd_go, cmd_ex;
  logic [6:0] cmd_rsel;
  logic       clk_run_async, shift_ir;
  logic       entry_req, ack_en, session_n, go_exit_stb, clk_run_sync, ir_status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 tck = ~tck;

  dbg_session_ctrl dut (
    .tck(tck), .rst_n(rst_n), .port_en(port_en), .evt_req_n(evt_req_n),
    .core_in_dbg(core_in_dbg), .upd_dr(upd_dr), .cmd_go(cmd_go), .cmd_ex(cmd_ex),
    .cmd_rsel(cmd_rsel), .clk_run_async(clk_run_async), .shift_ir(shift_ir),
    .entry_req(entry_req), .ack_en(ack_en), .session_n(session_n),
    .go_exit_stb(go_exit_stb), .clk_run_sync(clk_run_sync), .ir_status(ir_status)
  );

  // row: port_en, evt_req_n, core_in_dbg, upd/go/ex, rsel[6:0] |
  //      expected entry_req, ack_en, session_n, go_exit_stb (one edge later)
  localparam int NV = 23;
  localparam logic [16:0] VECS [NV] = '{
    17'b1_1_0_000_0000000_0_0_1_0, // 0  idle
    17'b0_0_0_000_0000000_0_0_1_0, // 1  R2 event while port disabled
    17'b1_0_0_000_0000000_1_0_1_0, // 2  R2 event taken
    17'b1_1_0_000_0000000_1_0_1_0, // 3  R2 request held
    17'b1_1_1_000_0000000_0_1_0_0, // 4  R3/R4/R6 entry edge
    17'b1_1_1_000_0000000_0_1_0_0, // 5  R4 second ack cycle
    17'b1_1_1_000_0000000_0_1_0_0, // 6  R4 third ack cycle
    17'b1_1_1_000_0000000_0_0_0_0, // 7  R4 ack over
    17'b1_1_0_000_0000000_0_0_0_0, // 8  R6 step exit, session held
    17'b1_1_1_000_0000000_0_1_0_0, // 9  R6 re-entry
    17'b1_0_1_000_0000000_0_1_0_0, // 10 R2 ignored in debug
    17'b1_0_0_000_0000000_0_1_0_0, // 11 R5 ignored during ack
    17'b1_1_0_000_0000000_0_0_0_0, // 12 ack over
    17'b1_1_0_111_0000101_0_0_0_0, // 13 R7 other rsel: no release
    17'b1_1_0_110_1111111_0_0_0_0, // 14 R7 exit low: no release
    17'b1_1_0_011_1111111_0_0_0_0, // 15 R7 not in update: no release
    17'b1_1_0_111_0010000_0_0_1_0, // 16 R7 chain release, R8 no strobe
    17'b1_1_0_000_0000000_0_0_1_0, // 17 idle
    17'b1_1_0_111_1111111_0_0_1_1, // 18 R8 strobe outside debug
    17'b1_1_1_000_0000000_0_1_0_0, // 19 new session
    17'b1_1_1_111_1111111_0_1_1_1, // 20 R7/R8 release in debug
    17'b1_1_1_000_0000000_0_1_1_0, // 21 R4 third ack cycle
    17'b1_1_0_000_0000000_0_0_1_0  // 22 idle
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    @(negedge tck);
  endtask

  task automatic idle_inputs();
    port_en = 1'b1; evt_req_n = 1'b1; upd_dr = 1'b0; cmd_go = 1'b0;
    cmd_ex = 1'b0; cmd_rsel = 7'h00;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge tck);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; idle_inputs(); port_en = 1'b0; core_in_dbg = 1'b0;
    clk_run_async = 1'b1; shift_ir = 1'b0;
    repeat (3) step();
    chk("R1 reset entry_req", entry_req, 1'b0);
    chk("R1 reset ack_en", ack_en, 1'b0);
    chk("R1 reset session_n", session_n, 1'b1);
    chk("R1 reset go_exit_stb", go_exit_stb, 1'b0);
    chk("R1 reset clk_run_sync", clk_run_sync, 1'b0);
    clk_run_async = 1'b0;
    rst_n = 1'b1;
    repeat (3) step();

    for (int i = 0; i < NV; i++) begin
      {port_en, evt_req_n, core_in_dbg, upd_dr, cmd_go, cmd_ex, cmd_rsel} = VECS[i][16:4];
      step();
      chk($sformatf("R2/R3/R5 entry_req row %0d", i), entry_req,   VECS[i][3]);
      chk($sformatf("R4/R5 ack_en row %0d", i),       ack_en,      VECS[i][2]);
      chk($sformatf("R6/R7 session_n row %0d", i),    session_n,   VECS[i][1]);
      chk($sformatf("R8 go_exit_stb row %0d", i),     go_exit_stb, VECS[i][0]);
    end

    // R7: entry and release on the same edge, entry wins
    idle_inputs(); core_in_dbg = 1'b1; upd_dr = 1'b1; cmd_go = 1'b1; cmd_ex = 1'b1;
    cmd_rsel = 7'h7F;
    step();
    chk("R7 entry beats release session_n", session_n, 1'b0);
    chk("R8 strobe on coincident entry", go_exit_stb, 1'b1);
    idle_inputs();
    repeat (3) step();
    chk("R4 ack ends after three cycles", ack_en, 1'b0);
    core_in_dbg = 1'b0;
    step();

    // R9: synchronizer latency and Shift-IR gating
    clk_run_async = 1'b1; shift_ir = 1'b1;
    step();
    chk("R9 sync after one edge", clk_run_sync, 1'b0);
    chk("R9 status after one edge", ir_status, 1'b0);
    step();
    chk("R9 sync after two edges", clk_run_sync, 1'b1);
    chk("R9 status in Shift-IR", ir_status, 1'b1);
    shift_ir = 1'b0;
    #1;
    chk("R9 status outside Shift-IR", ir_status, 1'b0);

    // R1: reset in mid-session with a pending request
    @(negedge tck);
    evt_req_n = 1'b0;
    step();
    chk("R2 pending before reset", entry_req, 1'b1);
    chk("R6 session open before reset", session_n, 1'b0);
    #2 rst_n = 1'b0;
    #1;
    chk("R1 mid-run reset entry_req", entry_req, 1'b0);
    chk("R1 mid-run reset session_n", session_n, 1'b1);
    chk("R1 mid-run reset ack_en", ack_en, 1'b0);
    chk("R1 mid-run reset clk_run_sync", clk_run_sync, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule